// File: doc/BRIEF.md
# Packed Alternating Add-Subtract Unit

This block is a registered floating-point datapath that works on packed vectors of IEEE-754 binary64 values. Each of the two source vectors holds up to four 64-bit lanes. Lanes with an odd index add the two sources. Lanes with an even index subtract the second source from the first. Every lane is a complete binary64 adder that rounds to nearest-even. It handles subnormal values without flushing them, and it handles signed zeros, infinities and NaNs.

A two-bit mode input sets how many lanes are computed and what the upper half of the 256-bit result holds. Two narrow modes compute only lanes 0 and 1. The first narrow mode copies the upper half from the prior destination input. The second narrow mode clears the upper half. In the wide mode all four lanes are computed. The prior destination input matters only for the upper half in the preserving narrow mode. In that mode software normally supplies the same data as the first source, because the destination register doubles as the first source.

Operations are accepted through a valid/ready handshake. The result register loads on the clock edge that accepts an operation, so the result appears one cycle after acceptance. It is then held until the consumer takes it. Four exception flags come with each result. Each flag is the OR of that flag over the lanes that were computed.

Top module: `alt_addsub_unit`

## Requirements
- R1: Lanes 0 and 2 return the correctly rounded value of first source minus second source (lane i occupies bits 64*i+63 down to 64*i).
- R2: Lanes 1 and 3 return the correctly rounded value of first source plus second source.
- R3: Every finite result is rounded to nearest with ties to even. Subnormal inputs and results keep their exact values, with no flush to zero.
- R4: With mode 2'b00, only lanes 0 and 1 are computed, and result bits 255:128 equal bits 255:128 of the prior destination input.
- R5: With mode 2'b01, only lanes 0 and 1 are computed, and result bits 255:128 are zero.
- R6: With mode 2'b10 or 2'b11, all four lanes are computed.
- R7: If the first operand is a NaN, it is returned with fraction bit 51 set. Otherwise, if the second operand is a NaN, that operand is returned, again with bit 51 set and with its own sign, even in a subtracting lane. Infinities of opposite effective sign return 64'hFFF8_0000_0000_0000. An infinity combined with a finite value returns that infinity, with its effective sign.
- R8: An exact zero sum of operands with opposite effective signs is +0. The sum of two zeros with the same effective sign keeps that sign.
- R9: The flags are ORed over the computed lanes only. Invalid is set for inf-inf or any signaling NaN input (bit 51 clear). Overflow returns a correctly signed infinity and sets both overflow and inexact. Inexact marks any rounded result. Underflow is set only for a tiny, inexact result.
- R10: in_ready equals !out_valid || out_ready. The result is valid in the cycle after acceptance. While out_valid is high and out_ready is low, the result and flags hold steady.
- R11: During and after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_mode | input | 2 | 00 narrow preserve, 01 narrow clear, 1x wide |
| in_src1 | input | 256 | First source vector, four binary64 lanes |
| in_src2 | input | 256 | Second source vector |
| in_dest | input | 256 | Prior destination contents |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 256 | Packed result |
| out_invalid | output | 1 | Invalid operation in a computed lane |
| out_overflow | output | 1 | Overflow in a computed lane |
| out_underflow | output | 1 | Tiny and inexact result in a computed lane |
| out_inexact | output | 1 | Rounded result in a computed lane |

## Verification
The bench puts inf-inf into the uncomputed upper lanes in narrow mode. An adder that ORed flags from every lane would then raise invalid. It also checks the upper half in each narrow mode, which a mux that confused keeping with clearing would get wrong. Rounding is tested with exact ties and with massive cancellation, since a design with too few guard bits or a tie rounded away from even would miss by one unit. The bench also tests subnormal sums that cross into the normal range, and a signaling NaN arriving as the second operand of a subtracting lane. A design that flipped that NaN's sign or left it signaling would return the wrong bits. Random operands under random backpressure catch lost, duplicated or unstable results.

// File: rtl/aas_pkg.sv
package aas_pkg;
  typedef enum logic [1:0] {
    MODE_N_KEEP = 2'b00,
    MODE_N_ZERO = 2'b01,
    MODE_WIDE   = 2'b10,
    MODE_WIDE_B = 2'b11
  } mode_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fp_flags_t;
endpackage

// File: rtl/aas_lzc.sv
module aas_lzc #(
  parameter int W  = 56,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  // Scan low to high; the highest set bit is the last one to write cnt.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/aas_lane.sv
module aas_lane
  import aas_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] opa,
  input  logic [EXP_W+FRAC_W:0] opb,
  input  logic                  sub_en,
  output logic [EXP_W+FRAC_W:0] res,
  output fp_flags_t             flg
);
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int MW = FRAC_W + 1;      // significand with hidden bit
  localparam int GW = 3;               // guard, round, sticky
  localparam int SW = MW + GW;
  localparam int CW = $clog2(SW + 1);
  localparam int EW = EXP_W + 1;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DEF_NAN = {1'b1, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};

  // stage A: unpack, order by magnitude, align, add
  logic             sa, sb, swap, eff_sub, a_nan, b_nan, a_inf, b_inf, a_snan, b_snan;
  logic [EXP_W-1:0] ea, eb, eea, eeb, e_l, e_s, d;
  logic [MW-1:0]    ma, mb, m_l, m_s;
  logic             s_l;
  logic [SW-1:0]    sm_ext, sm_sh, sm_mask, bg;
  logic             lost;
  logic [SW:0]      sum;
  logic [CW-1:0]    lz;

  always_comb begin
    sa   = opa[W-1];
    sb   = opb[W-1] ^ sub_en;   // subtraction = addition of a negated operand
    ea   = opa[W-2:FRAC_W];
    eb   = opb[W-2:FRAC_W];
    a_nan  = (ea == EMAX) && (opa[FRAC_W-1:0] != '0);
    b_nan  = (eb == EMAX) && (opb[FRAC_W-1:0] != '0);
    a_inf  = (ea == EMAX) && (opa[FRAC_W-1:0] == '0);
    b_inf  = (eb == EMAX) && (opb[FRAC_W-1:0] == '0);
    a_snan = a_nan && !opa[FRAC_W-1];
    b_snan = b_nan && !opb[FRAC_W-1];
    eea  = (ea == '0) ? EXP_W'(1) : ea;
    eeb  = (eb == '0) ? EXP_W'(1) : eb;
    ma   = {(ea != '0), opa[FRAC_W-1:0]};
    mb   = {(eb != '0), opb[FRAC_W-1:0]};
    swap = opb[W-2:0] > opa[W-2:0];
    e_l  = swap ? eeb : eea;
    e_s  = swap ? eea : eeb;
    m_l  = swap ? mb : ma;
    m_s  = swap ? ma : mb;
    s_l  = swap ? sb : sa;
    eff_sub = sa ^ sb;
    d    = e_l - e_s;
    bg     = {m_l, {GW{1'b0}}};
    sm_ext = {m_s, {GW{1'b0}}};
    sm_mask = '0;
    if (32'(d) >= SW) begin
      sm_sh = '0;
      lost  = |sm_ext;
    end else begin
      sm_sh   = sm_ext >> d;
      sm_mask = (SW'(1) << d) - SW'(1);
      lost    = |(sm_ext & sm_mask);
    end
    sm_sh[0] = sm_sh[0] | lost;
    if (eff_sub) sum = {1'b0, bg} - {1'b0, sm_sh};
    else         sum = {1'b0, bg} + {1'b0, sm_sh};
  end

  aas_lzc #(.W(SW)) u_lzc (
    .din (sum[SW-1:0]),
    .cnt (lz)
  );

  // stage B: normalise, round, pack, special operands
  logic [EW-1:0]  maxsh, sh, e_n, e_r;
  logic [SW-1:0]  norm;
  logic [MW-1:0]  keep, mant;
  logic           g, rs, inc, inx, ovf, tiny;
  logic [MW:0]    rnd;
  logic [EXP_W-1:0] field;

  always_comb begin
    maxsh = {1'b0, e_l} - EW'(1);
    sh    = '0;
    if (sum[SW]) begin
      norm = {sum[SW:2], sum[1] | sum[0]};
      e_n  = {1'b0, e_l} + EW'(1);
    end else begin
      sh   = (EW'(lz) < maxsh) ? EW'(lz) : maxsh;   // stop at the minimum exponent
      norm = sum[SW-1:0] << sh;
      e_n  = {1'b0, e_l} - sh;
    end
    keep = norm[SW-1:GW];
    g    = norm[GW-1];
    rs   = |norm[GW-2:0];
    inc  = g & (rs | keep[0]);
    rnd  = {1'b0, keep} + (MW+1)'(inc);
    if (rnd[MW]) begin
      mant = rnd[MW:1];
      e_r  = e_n + EW'(1);
    end else begin
      mant = rnd[MW-1:0];
      e_r  = e_n;
    end
    inx   = g | rs;
    tiny  = !mant[MW-1];
    ovf   = mant[MW-1] && (e_r >= {1'b0, EMAX});
    field = mant[MW-1] ? e_r[EXP_W-1:0] : '0;

    flg = '0;
    if (a_nan) begin
      res = opa | QBIT;
      flg.invalid = a_snan | b_snan;
    end else if (b_nan) begin
      res = opb | QBIT;
      flg.invalid = b_snan;
    end else if (a_inf && b_inf && eff_sub) begin
      res = DEF_NAN;
      flg.invalid = 1'b1;
    end else if (a_inf) begin
      res = opa;
    end else if (b_inf) begin
      res = {sb, opb[W-2:0]};
    end else if (sum == '0) begin
      res = {(eff_sub ? 1'b0 : sa), {(W-1){1'b0}}};
    end else if (ovf) begin
      res = {s_l, EMAX, {FRAC_W{1'b0}}};
      flg.overflow = 1'b1;
      flg.inexact  = 1'b1;
    end else begin
      res = {s_l, field, mant[FRAC_W-1:0]};
      flg.inexact   = inx;
      flg.underflow = tiny & inx;
    end
  end

  always_comb begin
    assert_ovf_inexact_R9: assert (!flg.overflow || flg.inexact)
      else $error("overflow without inexact");
    assert_quiet_nan_R7: assert (!((res[W-2:FRAC_W] == EMAX) && (res[FRAC_W-1:0] != '0)) || res[FRAC_W-1])
      else $error("signaling NaN produced");
  end
endmodule

// File: rtl/aas_lane_bank.sv
module aas_lane_bank
  import aas_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] src1,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] src2,
  output logic [LANES*(1+EXP_W+FRAC_W)-1:0] lane_res,
  output fp_flags_t [LANES-1:0]             lane_flg
);
  localparam int LW = 1 + EXP_W + FRAC_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // even index subtracts, odd index adds
    localparam logic SUB = ((i % 2) == 0);
    aas_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
      .opa    (src1[i*LW +: LW]),
      .opb    (src2[i*LW +: LW]),
      .sub_en (SUB),
      .res    (lane_res[i*LW +: LW]),
      .flg    (lane_flg[i])
    );
  end
endmodule

// File: rtl/alt_addsub_unit.sv
module alt_addsub_unit
  import aas_pkg::*;
#(
  parameter int LANES        = 4,
  parameter int NARROW_LANES = 2,
  parameter int EXP_W        = 11,
  parameter int FRAC_W       = 52
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [1:0]                          in_mode,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0]   in_src1,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0]   in_src2,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0]   in_dest,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [LANES*(1+EXP_W+FRAC_W)-1:0]   out_result,
  output logic                                out_invalid,
  output logic                                out_overflow,
  output logic                                out_underflow,
  output logic                                out_inexact
);
  localparam int LW = 1 + EXP_W + FRAC_W;
  localparam int VW = LANES * LW;
  localparam int NW = NARROW_LANES * LW;

  logic [VW-1:0]          lane_res, nxt_res;
  fp_flags_t [LANES-1:0]  lane_flg;
  fp_flags_t              nxt_flg, flg_q;
  logic                   accept;

  aas_lane_bank #(.LANES(LANES), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_bank (
    .src1     (in_src1),
    .src2     (in_src2),
    .lane_res (lane_res),
    .lane_flg (lane_flg)
  );

  // Mode selects per lane: computed, preserved from the destination, or cleared.
  always_comb begin
    nxt_res = '0;
    nxt_flg = '0;
    for (int i = 0; i < LANES; i++) begin
      if (in_mode[1] || (i < NARROW_LANES)) begin
        nxt_res[i*LW +: LW] = lane_res[i*LW +: LW];
        nxt_flg = fp_flags_t'(nxt_flg | lane_flg[i]);
      end else if (in_mode == MODE_N_KEEP) begin
        nxt_res[i*LW +: LW] = in_dest[i*LW +: LW];
      end
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      flg_q      <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_result <= nxt_res;
        flg_q      <= nxt_flg;
      end
    end
  end

  assign out_invalid   = flg_q.invalid;
  assign out_overflow  = flg_q.overflow;
  assign out_underflow = flg_q.underflow;
  assign out_inexact   = flg_q.inexact;

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(flg_q)))
    else $error("result changed while stalled");

  assert_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid))
    else $error("result appeared without an accepted operation");

  assert_keep_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == MODE_N_KEEP) |=> (out_result[VW-1:NW] == $past(in_dest[VW-1:NW])))
    else $error("upper bits not preserved");

  assert_clear_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && in_mode == MODE_N_ZERO) |=> (out_result[VW-1:NW] == '0))
    else $error("upper bits not cleared");
endmodule

// File: tb/alt_addsub_unit_bench.sv
module alt_addsub_unit_bench;
  localparam int CYCLE_LIMIT = 100000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] DNAN = 64'hFFF8_0000_0000_0000;
  localparam logic [63:0] DMAX = 64'h7FEF_FFFF_FFFF_FFFF;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready;
  logic [1:0] in_mode = 0;
  logic [255:0] in_src1 = 0, in_src2 = 0, in_dest = 0, out_result;
  logic out_invalid, out_overflow, out_underflow, out_inexact;

  int n_tests = 0, n_fail = 0;
  bit done = 0, bp_en = 0;

  logic [255:0] q_res[$];
  logic [3:0]   q_flg[$];
  bit           q_chk[$];
  string        q_req[$];

  always #4 clk = ~clk;

  alt_addsub_unit u_alt_addsub_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
    .in_src1(in_src1), .in_src2(in_src2), .in_dest(in_dest), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_invalid(out_invalid),
    .out_overflow(out_overflow), .out_underflow(out_underflow), .out_inexact(out_inexact)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] got, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_op(input logic [63:0] a, input logic [63:0] b, input bit sub);
    real ra, rb;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    return sub ? $realtobits(ra - rb) : $realtobits(ra + rb);
  endfunction

  // expected vector for finite/infinite non-NaN operands: R1 R2 R4 R5 R6
  function automatic logic [255:0] compose(input logic [1:0] mode, input logic [255:0] s1,
                                           input logic [255:0] s2, input logic [255:0] dst);
    logic [255:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (mode[1] || i < 2) r[i*64 +: 64] = ref_op(s1[i*64 +: 64], s2[i*64 +: 64], (i % 2) == 0);
      else if (mode == 2'b00) r[i*64 +: 64] = dst[i*64 +: 64];
    end
    return r;
  endfunction

  function automatic logic [63:0] d(input real v);
    return $realtobits(v);
  endfunction

  function automatic logic [63:0] rnd_dbl(input logic [63:0] near);
    int k;
    logic [10:0] e;
    logic [51:0] f;
    k = int'($urandom % 4);
    f = {20'($urandom), $urandom};
    case (k)
      0: e = 11'($urandom % 2047);
      1: e = 11'd0;
      2: e = 11'(1020 + $urandom % 7);
      default: return {near[63:8], 8'($urandom)};
    endcase
    return {1'($urandom), e, f};
  endfunction

  task automatic push(input logic [1:0] mode, input logic [255:0] s1, input logic [255:0] s2,
                      input logic [255:0] dst, input logic [255:0] er, input logic [3:0] ef,
                      input bit cf, input string req);
    @(negedge clk);
    in_mode = mode; in_src1 = s1; in_src2 = s2; in_dest = dst; in_valid = 1;
    q_res.push_back(er); q_flg.push_back(ef); q_chk.push_back(cf); q_req.push_back(req);
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  // backpressure driver
  initial begin
    out_ready = 1;
    forever begin
      @(negedge clk);
      out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic [255:0] prev_res;
    bit prev_stall;
    prev_stall = 0;
    prev_res = '0;
    forever begin
      @(negedge clk); #2;
      if (!rst) begin
        if (prev_stall)
          chk(out_valid === 1'b1 && out_result === prev_res, "R10 hold", out_result, prev_res);
        if (out_valid && out_ready) begin
          if (q_res.size() == 0) begin
            chk(0, "R10 unexpected result", out_result, '0);
          end else begin
            logic [255:0] er;
            logic [3:0] ef, gf;
            bit cf;
            string rq;
            er = q_res.pop_front(); ef = q_flg.pop_front();
            cf = q_chk.pop_front(); rq = q_req.pop_front();
            gf = {out_invalid, out_overflow, out_underflow, out_inexact};
            chk(out_result === er, rq, out_result, er);
            if (cf) chk(gf === ef, {rq, " flags"}, 256'(gf), 256'(ef));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_res = out_result;
      end
    end
  end

  // watchdog
  initial begin
    repeat (CYCLE_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] s1, s2, dst;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R11 in reset", {out_valid, in_ready}, 2'b01);
    rst = 0;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R11 after reset", {out_valid, in_ready}, 2'b01);

    // R1 R2 R6: exact arithmetic in wide mode; R10 latency of one cycle
    s1 = {d(10.0), d(-3.0), d(2.0), d(1.5)};
    s2 = {d(-2.5), d(1.0), d(0.5), d(0.25)};
    dst = {4{64'hA5A5_5A5A_0F0F_F0F0}};
    push(2'b10, s1, s2, dst, compose(2'b10, s1, s2, dst), 4'b0000, 1, "R1 R2 R6 wide basic");
    #2;
    chk(out_valid === 1'b1, "R10 latency", out_valid, 1);
    // R4 with inf-inf in uncomputed lane 2: R9 flags ignore it
    s1[191:128] = PINF; s2[191:128] = PINF;
    push(2'b00, s1, s2, dst, compose(2'b00, s1, s2, dst), 4'b0000, 1, "R4 R9 narrow keep");
    push(2'b01, s1, s2, dst, compose(2'b01, s1, s2, dst), 4'b0000, 1, "R5 R9 narrow clear");
    s1 = {d(10.0), d(-3.0), d(2.0), d(1.5)};
    s2 = {d(-2.5), d(1.0), d(0.5), d(0.25)};
    push(2'b11, s1, s2, dst, compose(2'b11, s1, s2, dst), 4'b0000, 1, "R6 mode 11");

    // R7: inf-inf gives the default NaN
    s1 = {d(1.0), d(1.0), PINF, PINF};
    s2 = {d(1.0), d(1.0), NINF, PINF};
    push(2'b10, s1, s2, 0, {d(2.0), 64'd0, DNAN, DNAN}, 4'b1000, 1, "R7 R9 inf minus inf");
    // R7: NaN propagation order and quieting
    s1 = {d(1.0), 64'h7FF8_0000_0000_0005, d(1.0), 64'h7FF0_0000_0000_0001};
    s2 = {d(2.0), 64'h7FF0_0000_0000_0007, 64'hFFF8_0000_0000_1234, d(3.0)};
    push(2'b10, s1, s2, 0,
         {d(3.0), 64'h7FF8_0000_0000_0005, 64'hFFF8_0000_0000_1234, 64'h7FF8_0000_0000_0001},
         4'b1000, 1, "R7 NaN propagation");
    s1 = {PINF, PINF, d(1.0), d(2.0)};
    s2 = {PINF, PINF, d(1.0), 64'h7FF4_0000_0000_0000};
    push(2'b01, s1, s2, 0, {128'd0, d(2.0), 64'h7FFC_0000_0000_0000}, 4'b1000, 1,
         "R7 signaling NaN as subtrahend");
    // R7: infinity with finite values
    s1 = {NINF, d(5.0), d(5.0), PINF};
    s2 = {NINF, PINF, NINF, d(5.0)};
    push(2'b10, s1, s2, 0, {NINF, NINF, NINF, PINF}, 4'b0000, 1, "R7 infinity operands");

    // R8: signed zeros
    s1 = {d(3.0), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, d(5.0)};
    s2 = {d(-3.0), 64'd0, 64'h8000_0000_0000_0000, d(5.0)};
    push(2'b10, s1, s2, 0, {64'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0},
         4'b0000, 1, "R8 signed zeros");

    // R9: overflow to correctly signed infinity
    s1 = {d(1.0), d(1.0), DMAX, DMAX | 64'h8000_0000_0000_0000};
    s2 = {d(1.0), d(1.0), DMAX, DMAX};
    push(2'b10, s1, s2, 0, {d(2.0), 64'd0, PINF, NINF}, 4'b0101, 1, "R9 overflow");

    // R3: rounding ties and cancellation, inexact only
    s1 = {d(1.0), 64'h3FF0_0000_0000_0001, d(1.0), d(1.0)};
    s2 = {64'h3CA0_0000_0000_0000, 64'hBCA0_0000_0000_0000, 64'h3C30_0000_0000_0000, 64'h3C30_0000_0000_0000};
    push(2'b10, s1, s2, 0, {d(1.0), 64'h3FF0_0000_0000_0002, d(1.0), d(1.0)},
         4'b0001, 1, "R3 R9 round to nearest even");

    // R3: subnormal operands and results
    s1 = {64'h0000_0000_0000_0007, 64'h0010_0000_0000_0000, 64'h0008_0000_0000_0000, 64'h0000_0000_0000_0003};
    s2 = {64'h8000_0000_0000_0002, 64'h0000_0000_0000_0001, 64'h0008_0000_0000_0000, 64'h0000_0000_0000_0001};
    push(2'b10, s1, s2, 0,
         {64'h0000_0000_0000_0005, 64'h000F_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000, 64'h0000_0000_0000_0002},
         4'b0000, 1, "R3 subnormals");
    idle();

    // random operands, random modes, random backpressure: R1 R2 R3 R4 R5 R6 R10
    bp_en = 1;
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      for (int i = 0; i < 4; i++) begin
        s1[i*64 +: 64] = rnd_dbl(64'h3FF0_0000_0000_0000);
        s2[i*64 +: 64] = rnd_dbl(s1[i*64 +: 64]);
      end
      dst = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      push(m, s1, s2, dst, compose(m, s1, s2, dst), 4'b0000, 0, "R1 R2 R3 random");
      if (($urandom % 5) == 0) idle();
    end
    idle();
    bp_en = 0;
    while (q_res.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R10 drained", out_valid, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule